// File: doc/BRIEF.md
# Four-Threshold Load Level Encoder

This block turns an averaged 16-bit duty measurement into a load level. The upper 12 bits of each new duty sample are compared against four ordered 12-bit thresholds. The result places the load in one of five stages, numbered 0 (below the lowest threshold) to 4 (above the highest). From the stage the block produces four outputs: a 2-bit stage code for an external clock or voltage controller, three live condition flags, a single-threshold turbo request, and a 3-bit code taken from a programmable five-entry table.

The two end comparisons can each be taken out of service. Optional hysteresis gives each threshold its own lower return value. A downward crossing of a threshold then only takes effect once duty falls below that return value. A watchdog measures how long the level is held up by hysteresis alone. When that time runs out, and also when an external fault-disable line is low while that feature is enabled, the block swaps the table code for a standby code. Evaluation runs only on the duty update strobe, so every output is registered and changes at most once per measurement window.

Top module: `load_level_encoder`

## Requirements
- R1: On each strobe the block compares `duty_i[15:4]` strictly against the thresholds. Threshold k sits at `lim_i[12k+11:12k]`, and they are ordered threshold 3 > 2 > 1 > 0. The stage index is the number of thresholds exceeded. `stage_o` encodes stage 4 as 00, stage 3 as 01, stage 2 as 10, stage 1 as 11 and stage 0 as 00.
- R2: A duty value exactly equal to a threshold never moves the stage across that threshold: if the previous stage lies on either side of it, that stage is kept.
- R3: With `dis_top_i` high, threshold 3 is never treated as exceeded, so duty above it stays in stage 3 (code 01) and does not raise the fault flag.
- R4: With `dis_bot_i` high, threshold 0 is always treated as exceeded, so duty below it stays in stage 1 (code 11) and does not raise the fault flag.
- R5: On each strobe, `over_o` is set when duty > threshold 2, `under_o` when duty < threshold 1, and `fault_o` when duty is above a threshold 3 that is in service or below a threshold 0 that is in service. Each flag clears on the first strobe where its condition is gone.
- R6: `turbo_o` follows `under_o`'s condition when `turbo_sel_i` is 0 and `over_o`'s condition when it is 1.
- R7: `tcode_o` is the table entry for the new stage. Entry k sits at `code_tbl_i[3k+2:3k]`.
- R8: With `hys_en_i` high, crossing threshold k downward needs duty < `ret_i[12k+11:12k]`, the return value. Upward crossings still use the threshold itself.
- R9: A band evaluation is one where hysteresis leaves the stage different from the stage plain thresholds would give. The block counts consecutive band evaluations; any other evaluation clears the count. With `wd_en_i` high, once the count exceeds `wd_limit_i`, `tcode_o` shows `standby_i`.
- R10: When `fdis_en_i` is high and `fault_in_n_i` is low at a strobe, `tcode_o` shows `standby_i`.
- R11: After reset all outputs are 0 and the stage is 0. Without a strobe no output changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | 16 | Averaged duty value |
| duty_vld_i | input | 1 | Strobe: duty_i is new, evaluate |
| lim_i | input | 48 | Four 12-bit thresholds, threshold k at [12k+11:12k] |
| ret_i | input | 48 | Four 12-bit return values, same packing |
| hys_en_i | input | 1 | Hysteresis enable |
| dis_top_i | input | 1 | Take threshold 3 out of service |
| dis_bot_i | input | 1 | Take threshold 0 out of service |
| turbo_sel_i | input | 1 | 0: turbo on under threshold 1; 1: on over threshold 2 |
| wd_en_i | input | 1 | Watchdog enable |
| wd_limit_i | input | 5 | Watchdog count limit |
| code_tbl_i | input | 15 | Five 3-bit stage codes, stage k at [3k+2:3k] |
| standby_i | input | 3 | Standby code |
| fdis_en_i | input | 1 | Fault-disable input enable |
| fault_in_n_i | input | 1 | Fault-disable input, active low |
| stage_o | output | 2 | Stage code |
| over_o | output | 1 | Duty above threshold 2 |
| under_o | output | 1 | Duty below threshold 1 |
| fault_o | output | 1 | Duty beyond an in-service end threshold |
| turbo_o | output | 1 | Single-threshold turbo request |
| tcode_o | output | 3 | Table or standby code |

## Verification
The hardest state to reach is a watchdog timeout. It needs hysteresis on, a stage first raised above a threshold, and then a run of consecutive strobes whose duty sits between that threshold and its return value; any strobe outside the band resets the run. The random stimulus aims most duty values within a few counts of a threshold or return value and keeps watchdog limits small, so such runs occur often. Directed sequences also walk a level up and then hold it in the band for exactly limit and limit+1 strobes. Equal-to-threshold samples come from the same aimed offsets, approached from both sides.

// File: rtl/lle_pkg.sv
package lle_pkg;
  localparam int unsigned NUM_LIM = 4;
  localparam int unsigned NUM_STG = NUM_LIM + 1;
  localparam int unsigned STG_W   = $clog2(NUM_STG);

  typedef logic [STG_W-1:0] stage_t;

  // number of set bits in a threshold vector
  function automatic stage_t ones(input logic [NUM_LIM-1:0] v);
    stage_t n;
    n = '0;
    for (int i = 0; i < NUM_LIM; i++) n = n + stage_t'(v[i]);
    return n;
  endfunction

  // 2-bit stage code seen by the downstream controller
  function automatic logic [1:0] stage_code(input stage_t s);
    logic [1:0] c;
    case (s)
      stage_t'(3): c = 2'b01;
      stage_t'(2): c = 2'b10;
      stage_t'(1): c = 2'b11;
      default:     c = 2'b00;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/lle_cmp.sv
module lle_cmp #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] d,
  input  logic [W-1:0] lim,
  input  logic [W-1:0] ret,
  input  logic         use_ret,
  input  logic         frc_pass,
  input  logic         frc_fail,
  output logic         gt,
  output logic         ge,
  output logic         gt_plain,
  output logic         ge_plain
);
  logic [W-1:0] thr;

  always_comb begin
    thr      = use_ret ? ret : lim;
    gt       = frc_pass | (~frc_fail & (d >  thr));
    ge       = frc_pass | (~frc_fail & (d >= thr));
    gt_plain = frc_pass | (~frc_fail & (d >  lim));
    ge_plain = frc_pass | (~frc_fail & (d >= lim));
  end
endmodule

// File: rtl/lle_stage_sel.sv
module lle_stage_sel
  import lle_pkg::*;
(
  input  logic [NUM_LIM-1:0] gt,
  input  logic [NUM_LIM-1:0] ge,
  input  logic [NUM_LIM-1:0] gt_plain,
  input  logic [NUM_LIM-1:0] ge_plain,
  input  stage_t             prev,
  output stage_t             nxt,
  output stage_t             plain
);
  stage_t lo, hi, lo_p, hi_p;

  always_comb begin
    lo   = ones(gt);
    hi   = ones(ge);
    lo_p = ones(gt_plain);
    hi_p = ones(ge_plain);
    // clamp previous stage into the window the compares allow
    if (prev < lo)      nxt = lo;
    else if (prev > hi) nxt = hi;
    else                nxt = prev;
    if (prev < lo_p)      plain = lo_p;
    else if (prev > hi_p) plain = hi_p;
    else                  plain = prev;
  end
endmodule

// File: rtl/lle_wdog.sv
module lle_wdog #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          band,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          expire_nxt
);
  localparam logic [CW:0] CMAX = '1;

  logic [CW:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (evt) begin
      if (!band)             cnt_d = '0;
      else if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    end
    expire_nxt = en & band & (cnt_d > {1'b0, limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (evt) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/load_level_encoder.sv
module load_level_encoder
  import lle_pkg::*;
#(
  parameter int unsigned DUTY_W = 16,
  parameter int unsigned LIM_W  = 12,
  parameter int unsigned CODE_W = 3,
  parameter int unsigned WD_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DUTY_W-1:0]           duty_i,
  input  logic                        duty_vld_i,
  input  logic [NUM_LIM*LIM_W-1:0]    lim_i,
  input  logic [NUM_LIM*LIM_W-1:0]    ret_i,
  input  logic                        hys_en_i,
  input  logic                        dis_top_i,
  input  logic                        dis_bot_i,
  input  logic                        turbo_sel_i,
  input  logic                        wd_en_i,
  input  logic [WD_W-1:0]             wd_limit_i,
  input  logic [NUM_STG*CODE_W-1:0]   code_tbl_i,
  input  logic [CODE_W-1:0]           standby_i,
  input  logic                        fdis_en_i,
  input  logic                        fault_in_n_i,
  output logic [1:0]                  stage_o,
  output logic                        over_o,
  output logic                        under_o,
  output logic                        fault_o,
  output logic                        turbo_o,
  output logic [CODE_W-1:0]           tcode_o
);
  localparam int unsigned TOP = NUM_LIM - 1;

  logic [LIM_W-1:0]   d;
  logic [NUM_LIM-1:0] gt, ge, gt_p, ge_p;
  stage_t             stage_q, stage_d, plain;
  logic               band, wd_expire, standby_sel;
  logic               over_d, under_d, fault_d, turbo_d;
  logic [CODE_W-1:0]  tcode_d;
  logic [LIM_W-1:0]   lim_top, lim_bot;

  assign d       = duty_i[DUTY_W-1 -: LIM_W];
  assign lim_top = lim_i[TOP*LIM_W +: LIM_W];
  assign lim_bot = lim_i[0 +: LIM_W];

  for (genvar k = 0; k < NUM_LIM; k++) begin : g_cmp
    lle_cmp #(.W(LIM_W)) u_cmp (
      .d        (d),
      .lim      (lim_i[k*LIM_W +: LIM_W]),
      .ret      (ret_i[k*LIM_W +: LIM_W]),
      .use_ret  (hys_en_i && (stage_q > stage_t'(k))),
      .frc_pass ((k == 0) ? dis_bot_i : 1'b0),
      .frc_fail ((k == TOP) ? dis_top_i : 1'b0),
      .gt       (gt[k]),
      .ge       (ge[k]),
      .gt_plain (gt_p[k]),
      .ge_plain (ge_p[k])
    );
  end

  lle_stage_sel u_sel (
    .gt       (gt),
    .ge       (ge),
    .gt_plain (gt_p),
    .ge_plain (ge_p),
    .prev     (stage_q),
    .nxt      (stage_d),
    .plain    (plain)
  );

  assign band = hys_en_i && (stage_d != plain);

  lle_wdog #(.CW(WD_W)) u_wd (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (duty_vld_i),
    .band       (band),
    .en         (wd_en_i),
    .limit      (wd_limit_i),
    .expire_nxt (wd_expire)
  );

  always_comb begin
    over_d      = d > lim_i[2*LIM_W +: LIM_W];
    under_d     = d < lim_i[1*LIM_W +: LIM_W];
    fault_d     = (~dis_top_i & (d > lim_top)) | (~dis_bot_i & (d < lim_bot));
    turbo_d     = turbo_sel_i ? over_d : under_d;
    standby_sel = wd_expire | (fdis_en_i & ~fault_in_n_i);
    tcode_d     = code_tbl_i[stage_d*CODE_W +: CODE_W];
    if (standby_sel) tcode_d = standby_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      over_o  <= 1'b0;
      under_o <= 1'b0;
      fault_o <= 1'b0;
      turbo_o <= 1'b0;
      tcode_o <= '0;
    end else if (duty_vld_i) begin
      stage_q <= stage_d;
      over_o  <= over_d;
      under_o <= under_d;
      fault_o <= fault_d;
      turbo_o <= turbo_d;
      tcode_o <= tcode_d;
    end
  end

  assign stage_o = stage_code(stage_q);
endmodule

// File: rtl/lle_chk.sv
module lle_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] duty_i,
  input logic        duty_vld_i,
  input logic [47:0] lim_i,
  input logic        dis_top_i,
  input logic        dis_bot_i,
  input logic        fdis_en_i,
  input logic        fault_in_n_i,
  input logic [2:0]  standby_i,
  input logic [1:0]  stage_o,
  input logic        over_o,
  input logic        under_o,
  input logic        fault_o,
  input logic        turbo_o,
  input logic [2:0]  tcode_o
);
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_vld_i |=> $stable(stage_o) && $stable(tcode_o) && $stable(over_o) && $stable(fault_o)); // R11

  AST_FAULT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    duty_vld_i && !dis_top_i && (duty_i[15:4] > lim_i[47:36]) |=> fault_o); // R5

  AST_UNDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    duty_vld_i && (duty_i[15:4] < lim_i[23:12]) |=> under_o); // R5

  AST_ENDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    duty_vld_i && dis_top_i && dis_bot_i |=> stage_o != 2'b00); // R3

  AST_FDIS_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    duty_vld_i && fdis_en_i && !fault_in_n_i |=> tcode_o == $past(standby_i)); // R10

  AST_TURBO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    turbo_o |-> over_o || under_o); // R6
endmodule

bind load_level_encoder lle_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .duty_i       (duty_i),
  .duty_vld_i   (duty_vld_i),
  .lim_i        (lim_i),
  .dis_top_i    (dis_top_i),
  .dis_bot_i    (dis_bot_i),
  .fdis_en_i    (fdis_en_i),
  .fault_in_n_i (fault_in_n_i),
  .standby_i    (standby_i),
  .stage_o      (stage_o),
  .over_o       (over_o),
  .under_o      (under_o),
  .fault_o      (fault_o),
  .turbo_o      (turbo_o),
  .tcode_o      (tcode_o)
);

// File: tb/sim_load_level_encoder.sv
`timescale 1ns/1ps
module sim_load_level_encoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] duty_i;
  logic        duty_vld_i;
  logic [47:0] lim_i, ret_i;
  logic        hys_en_i, dis_top_i, dis_bot_i, turbo_sel_i, wd_en_i;
  logic [4:0]  wd_limit_i;
  logic [14:0] code_tbl_i;
  logic [2:0]  standby_i;
  logic        fdis_en_i, fault_in_n_i;
  logic [1:0]  stage_o;
  logic        over_o, under_o, fault_o, turbo_o;
  logic [2:0]  tcode_o;

  int total = 0;
  int bad   = 0;
  int lim[4];
  int ret[4];
  int m_stage = 0;
  int m_cnt   = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  load_level_encoder u0 (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit up_ok(int s, int d);
    if (s == 0 && dis_bot_i) return 1;
    if (s == 3 && dis_top_i) return 0;
    return d > lim[s];
  endfunction

  function automatic bit dn_ok(int s, int d, bit hys);
    if (s == 4 && dis_top_i) return 1;
    if (s == 1 && dis_bot_i) return 0;
    return d < (hys ? ret[s-1] : lim[s-1]);
  endfunction

  function automatic int walk(int prev, int d, bit hys);
    int s = prev;
    bit moved = 0;
    while (s < 4 && up_ok(s, d)) begin s++; moved = 1; end
    if (!moved) while (s > 0 && dn_ok(s, d, hys)) s--;
    return s;
  endfunction

  function automatic int code_of(int s);
    case (s)
      4: return 0;
      3: return 1;
      2: return 2;
      1: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic pack();
    for (int k = 0; k < 4; k++) begin
      lim_i[k*12 +: 12] = lim[k][11:0];
      ret_i[k*12 +: 12] = ret[k][11:0];
    end
  endtask

  // one evaluation: drive, step the model, check every output
  task automatic eval(int d12, string tag);
    int st, pl, ov, un, ft, tb, tc;
    bit band, expire;
    pack();
    duty_i     = 16'(d12 << 4) | 16'($urandom % 16);
    duty_vld_i = 1'b1;
    st   = walk(m_stage, d12, hys_en_i);
    pl   = walk(m_stage, d12, 1'b0);
    band = hys_en_i && (st != pl);
    m_cnt = band ? ((m_cnt < 63) ? m_cnt + 1 : 63) : 0;
    expire = wd_en_i && band && (m_cnt > int'(wd_limit_i));
    m_stage = st;
    ov = int'(d12 > lim[2]);
    un = int'(d12 < lim[1]);
    ft = int'((!dis_top_i && d12 > lim[3]) || (!dis_bot_i && d12 < lim[0]));
    tb = turbo_sel_i ? ov : un;
    tc = (expire || (fdis_en_i && !fault_in_n_i)) ? int'(standby_i)
                                                  : int'(code_tbl_i[st*3 +: 3]);
    @(negedge clk);
    duty_vld_i = 1'b0;
    chk({tag, " stage R1"}, int'(stage_o), code_of(st));
    chk({tag, " over R5"},  int'(over_o), ov);
    chk({tag, " under R5"}, int'(under_o), un);
    chk({tag, " fault R5"}, int'(fault_o), ft);
    chk({tag, " turbo R6"}, int'(turbo_o), tb);
    chk({tag, " tcode R7"}, int'(tcode_o), tc);
  endtask

  task automatic rand_limits();
    lim[0] = 100 + int'($urandom % 400);
    for (int k = 1; k < 4; k++) lim[k] = lim[k-1] + 50 + int'($urandom % 600);
    for (int k = 0; k < 4; k++) ret[k] = lim[k] - int'($urandom % 40);
  endtask

  function automatic int aim();
    int t, v;
    t = ($urandom % 2) ? lim[$urandom % 4] : ret[$urandom % 4];
    v = t + int'($urandom % 7) - 3;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; duty_i = '0; duty_vld_i = 1'b0;
    hys_en_i = 0; dis_top_i = 0; dis_bot_i = 0; turbo_sel_i = 0;
    wd_en_i = 0; wd_limit_i = 5'd31; fdis_en_i = 0; fault_in_n_i = 1;
    standby_i = 3'd5;
    code_tbl_i = {3'd4, 3'd3, 3'd2, 3'd1, 3'd6};
    lim = '{200, 800, 1600, 3000};
    ret = '{180, 700, 1500, 2900};
    pack();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("reset stage R11", int'(stage_o), 0);
    chk("reset tcode R11", int'(tcode_o), 0);
    chk("reset flags R11", int'({over_o, under_o, fault_o, turbo_o}), 0);

    // R1: each stage, plain thresholds
    eval(100, "stage0");  eval(500, "stage1");  eval(1000, "stage2");
    eval(2000, "stage3"); eval(3500, "stage4"); eval(1000, "down2");
    // R2: equality keeps the stage on both sides
    eval(1600, "eq from below R2");
    chk("eq below R2", int'(stage_o), 2);
    eval(2000, "to3"); eval(1600, "eq from above R2");
    chk("eq above R2", int'(stage_o), 1);
    // R3 / R4: end compares out of service
    dis_top_i = 1; eval(4000, "top off R3");
    chk("top off code R3", int'(stage_o), 1);
    dis_top_i = 0; dis_bot_i = 1; eval(10, "bot off R4");
    chk("bot off code R4", int'(stage_o), 3);
    dis_bot_i = 0;
    // R6: turbo select
    turbo_sel_i = 1; eval(2000, "sel1 R6"); turbo_sel_i = 0; eval(500, "sel0 R6");
    // R8: hysteresis holds stage 3 until below return value
    hys_en_i = 1; eval(2000, "hys up R8"); eval(1550, "hys hold R8");
    chk("hys held R8", int'(stage_o), 1);
    eval(1499, "hys drop R8");
    chk("hys dropped R8", int'(stage_o), 2);
    // R9: watchdog after limit+1 band evaluations
    wd_en_i = 1; wd_limit_i = 5'd2;
    eval(2000, "wd up R9");
    eval(1550, "wd b1 R9"); eval(1550, "wd b2 R9");
    chk("wd not yet R9", int'(tcode_o), 3);
    eval(1550, "wd b3 R9");
    chk("wd expired R9", int'(tcode_o), 5);
    eval(2000, "wd clear R9");
    chk("wd cleared R9", int'(tcode_o), 3);
    // R10: fault-disable input
    fdis_en_i = 1; fault_in_n_i = 0; eval(1000, "fdis R10");
    chk("fdis standby R10", int'(tcode_o), 5);
    fault_in_n_i = 1; fdis_en_i = 0;
    // R11: inputs move without strobe, outputs hold
    duty_i = 16'hFFF0; dis_top_i = 1; standby_i = 3'd0;
    @(negedge clk); @(negedge clk);
    chk("no strobe stage R11", int'(stage_o), code_of(m_stage));
    chk("no strobe flag R11", int'(over_o), 0);
    dis_top_i = 0; standby_i = 3'd5;

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0) begin
        rand_limits();
        hys_en_i    = 1'($urandom % 2);
        dis_top_i   = 1'($urandom % 4 == 0);
        dis_bot_i   = 1'($urandom % 4 == 0);
        turbo_sel_i = 1'($urandom % 2);
        wd_en_i     = 1'($urandom % 2);
        wd_limit_i  = 5'($urandom % 5);
        fdis_en_i   = 1'($urandom % 2);
        code_tbl_i  = 15'($urandom);
        standby_i   = 3'($urandom);
      end
      fault_in_n_i = 1'($urandom % 8 != 0);
      eval(aim(), "rand");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R11 act=hung exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule